// File: doc/BRIEF.md
# Signal-Strength Conversion Controller

This block decides when a received signal-strength level gets sampled by an external 5-bit converter, and it keeps the result in an 8-bit status register. Each time the receiver is enabled, a session starts. In a session the controller waits for a carrier indication that stays present without a break for a programmable number of reference-clock cycles. It then requests one conversion and stores the returned code next to a valid flag. After that it halts and takes no further samples until the receiver is switched off and on again. A software force input can start the conversion at once, without waiting for any carrier. This lets software measure the noise floor of a quiet channel.

The converter is a plain start/done port pair. The controller pulses `adc_start` for one cycle. Some cycles later the converter raises `adc_done` for one cycle, with the code on `adc_code`. There is no back-pressure on this interface: the controller is always ready to take the code while a conversion is pending. Outside a conversion, `adc_done` is ignored. The converter must answer within `CONV_MAX_CYCLES` cycles. This matches the software practice of waiting a fixed time after forcing before it reads the result.

Top module: `rssi_conv_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `rssi_status` is 8'h00 and `adc_start` is 0.
- R2: When the receiver has been enabled and the controller is armed, `adc_start` goes high in the cycle after the (QUAL_CYCLES+1)-th consecutive rising edge at which `carrier_det` was sampled high. It stays low at every earlier edge.
- R3: If `carrier_det` is sampled low before qualification completes, the qualification count restarts from zero. A full fresh run of QUAL_CYCLES+1 high samples is then needed.
- R4: In the armed state, a high sample of `force_cd` starts a conversion on that edge, whatever the state of the carrier. `adc_start` is high in the next cycle.
- R5: `adc_start` is high for exactly one cycle, and at most once per receive session.
- R6: A high `adc_done` sampled while a conversion is pending loads `adc_code` into bits 4:0 of `rssi_status` and sets bit 5 (the valid flag), visible in the next cycle.
- R7: After the capture the controller halts. `carrier_det`, `force_cd` and `adc_done` have no effect, and `rssi_status` holds its value while `rx_en` stays high.
- R8: A low sample of `rx_en` clears `rssi_status` to 8'h00 and drops any pending qualification or conversion on that edge. The first edge with `rx_en` high again arms the controller, and counting begins at the edge after that.
- R9: Bits 7:6 of `rssi_status` always read as 0.
- R10: A high `adc_done` sampled while no conversion is pending leaves `rssi_status` unchanged.
- R11: After `adc_start`, the converter answers with `adc_done` within CONV_MAX_CYCLES cycles, unless `rx_en` drops first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receive mode enable; each high period is one session |
| carrier_det | input | 1 | On-channel carrier present |
| force_cd | input | 1 | Software force: start a conversion without a carrier |
| adc_start | output | 1 | One-cycle conversion request to the converter |
| adc_done | input | 1 | One-cycle conversion complete strobe |
| adc_code | input | 5 | Converter result, valid with `adc_done` |
| rssi_status | output | 8 | Bits 4:0 code, bit 5 valid, bits 7:6 zero |

## Verification
The bench builds the controller with QUAL_CYCLES = 8 and CONV_MAX_CYCLES = 16. The short qualification window lets random carrier bursts both qualify and fall just short within a few cycles, so many full sessions fit into one run: arming, qualification, capture, halt and clearing. The converter model answers in 1 to 6 cycles, which stays inside the deadline, and it also injects stray done strobes whenever no conversion is pending. Directed runs place the carrier drop one sample before qualification completes, and they cover forcing from a silent channel.

// File: rtl/rssi_ctrl_pkg.sv
package rssi_ctrl_pkg;
  localparam int STATUS_W = 8;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_CONV  = 2'd2,
    ST_HALT  = 2'd3
  } rssi_state_e;
endpackage

// File: rtl/rssi_qual_timer.sv
module rssi_qual_timer #(
  parameter int QUAL_CYCLES = 650
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic carrier,
  output logic qualified
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  // Count consecutive carrier samples; any gap or disarm restarts from zero.
  always_ff @(posedge clk) begin
    if (!rst_n || !enable || !carrier) cnt_q <= '0;
    else if (cnt_q != LIMIT)           cnt_q <= cnt_q + 1'b1;
  end

  assign qualified = enable && carrier && (cnt_q == LIMIT);
endmodule

// File: rtl/rssi_conv_seq.sv
module rssi_conv_seq
  import rssi_ctrl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_en,
  input  logic        qualified,
  input  logic        force_req,
  input  logic        adc_done,
  output rssi_state_e state,
  output logic        adc_start,
  output logic        capture
);
  rssi_state_e state_q, state_d;
  logic        go;

  assign go      = (state_q == ST_ARMED) && (force_req || qualified);
  assign capture = rx_en && (state_q == ST_CONV) && adc_done;

  always_comb begin
    state_d = state_q;
    if (!rx_en) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:   state_d = ST_ARMED;
        ST_ARMED: if (go) state_d = ST_CONV;
        ST_CONV:  if (adc_done) state_d = ST_HALT;
        ST_HALT:  state_d = ST_HALT;
        default:  state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_OFF;
      adc_start <= 1'b0;
    end else begin
      state_q   <= state_d;
      adc_start <= rx_en && go;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/rssi_status_reg.sv
module rssi_status_reg
  import rssi_ctrl_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                capture,
  input  logic [CODE_W-1:0]   code,
  output logic [STATUS_W-1:0] status
);
  localparam int USED_W = CODE_W + 1;

  logic [USED_W-1:0] used_q;

  // Clear wins over capture; the valid flag sits just above the code.
  always_ff @(posedge clk) begin
    if (!rst_n || clear) used_q <= '0;
    else if (capture)    used_q <= {1'b1, code};
  end

  assign status = STATUS_W'(used_q);
endmodule

// File: rtl/rssi_conv_ctrl.sv
module rssi_conv_ctrl
  import rssi_ctrl_pkg::*;
#(
  parameter int QUAL_CYCLES     = 650,
  parameter int CONV_MAX_CYCLES = 650,
  parameter int CODE_W          = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_en,
  input  logic                carrier_det,
  input  logic                force_cd,
  output logic                adc_start,
  input  logic                adc_done,
  input  logic [CODE_W-1:0]   adc_code,
  output logic [STATUS_W-1:0] rssi_status
);
  rssi_state_e state;
  logic        qualified;
  logic        capture;

  rssi_qual_timer #(.QUAL_CYCLES(QUAL_CYCLES)) timer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (state == ST_ARMED),
    .carrier   (carrier_det),
    .qualified (qualified)
  );

  rssi_conv_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .qualified (qualified),
    .force_req (force_cd),
    .adc_done  (adc_done),
    .state     (state),
    .adc_start (adc_start),
    .capture   (capture)
  );

  rssi_status_reg #(.CODE_W(CODE_W)) status_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (!rx_en),
    .capture (capture),
    .code    (adc_code),
    .status  (rssi_status)
  );
endmodule

// File: rtl/rssi_conv_ctrl_chk.sv
module rssi_conv_ctrl_chk
  import rssi_ctrl_pkg::*;
#(
  parameter int QUAL_CYCLES     = 650,
  parameter int CONV_MAX_CYCLES = 650,
  parameter int CODE_W          = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rx_en,
  input logic                carrier_det,
  input logic                force_cd,
  input logic                adc_start,
  input logic                adc_done,
  input logic [CODE_W-1:0]   adc_code,
  input logic [STATUS_W-1:0] rssi_status
);
  localparam int RUN_W  = $clog2(QUAL_CYCLES + 2);
  localparam int WAIT_W = $clog2(CONV_MAX_CYCLES + 2);
  localparam logic [RUN_W-1:0]  RUN_SAT  = RUN_W'(QUAL_CYCLES + 1);
  localparam logic [WAIT_W-1:0] WAIT_SAT = WAIT_W'(CONV_MAX_CYCLES + 1);

  logic [RUN_W-1:0]  run_q;
  logic [WAIT_W-1:0] wait_q;
  logic              waiting_q;
  logic              started_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= '0;
      wait_q    <= '0;
      waiting_q <= 1'b0;
      started_q <= 1'b0;
    end else begin
      if (!(rx_en && carrier_det)) run_q <= '0;
      else if (run_q != RUN_SAT)   run_q <= run_q + 1'b1;

      if (!rx_en || adc_done) begin
        waiting_q <= 1'b0;
        wait_q    <= '0;
      end else if (adc_start) begin
        waiting_q <= 1'b1;
        wait_q    <= '0;
      end else if (waiting_q && wait_q != WAIT_SAT) begin
        wait_q <= wait_q + 1'b1;
      end

      if (!rx_en)         started_q <= 1'b0;
      else if (adc_start) started_q <= 1'b1;
    end
  end

  assert_start_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |-> ($past(force_cd) || run_q == RUN_SAT));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  assert_one_start_per_session_R5: assert property (@(posedge clk) disable iff (!rst_n)
    started_q |-> !adc_start);

  assert_capture_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rssi_status[CODE_W]) |-> ($past(adc_done) &&
      rssi_status[CODE_W-1:0] == $past(adc_code)));

  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rssi_status[CODE_W] && rx_en) |=> ($stable(rssi_status) && !adc_start));

  assert_clear_on_rx_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (rssi_status == '0 && !adc_start));

  assert_conv_deadline_R11: assert property (@(posedge clk) disable iff (!rst_n)
    waiting_q |-> (wait_q < WAIT_W'(CONV_MAX_CYCLES)));

  always @(posedge clk) begin
    if (rst_n) begin
      assert_upper_zero_R9: assert (rssi_status[STATUS_W-1:CODE_W+1] == '0);
    end
  end
endmodule

bind rssi_conv_ctrl rssi_conv_ctrl_chk #(
  .QUAL_CYCLES     (QUAL_CYCLES),
  .CONV_MAX_CYCLES (CONV_MAX_CYCLES),
  .CODE_W          (CODE_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_en       (rx_en),
  .carrier_det (carrier_det),
  .force_cd    (force_cd),
  .adc_start   (adc_start),
  .adc_done    (adc_done),
  .adc_code    (adc_code),
  .rssi_status (rssi_status)
);

// File: tb/rssi_conv_ctrl_tb_top.sv
module rssi_conv_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL       = 8;
  localparam int CONV_MAX   = 16;
  localparam int CODE_W     = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx_en = 1'b0;
  logic              carrier_det = 1'b0;
  logic              force_cd = 1'b0;
  logic              adc_done = 1'b0;
  logic [CODE_W-1:0] adc_code = '0;
  logic              adc_start;
  logic [7:0]        rssi_status;

  always #(CLK_PERIOD/2) clk = ~clk;

  rssi_conv_ctrl #(.QUAL_CYCLES(QUAL), .CONV_MAX_CYCLES(CONV_MAX), .CODE_W(CODE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .carrier_det(carrier_det),
    .force_cd(force_cd), .adc_start(adc_start), .adc_done(adc_done),
    .adc_code(adc_code), .rssi_status(rssi_status)
  );

  typedef enum {M_OFF, M_ARMED, M_CONV, M_HALT} m_state_e;

  int        n_checks = 0;
  int        n_fail = 0;
  bit        finished = 0;
  m_state_e  m_st = M_OFF;
  int        m_cnt = 0;
  logic [7:0] m_status = '0;
  logic      m_start = 1'b0;
  int        conv_wait = -1;
  bit        spurious = 0;
  string     tag = "";

  function automatic string state_tag(m_state_e s);
    case (s)
      M_OFF:   return "R8";
      M_ARMED: return "R2";
      M_CONV:  return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Expected behaviour at one rising edge, from the requirements.
  task automatic model_edge();
    if (!rst_n || !rx_en) begin
      m_st = M_OFF; m_cnt = 0; m_status = '0; m_start = 1'b0;
    end else begin
      m_start = 1'b0;
      case (m_st)
        M_OFF: m_st = M_ARMED;
        M_ARMED: begin
          if (force_cd || (carrier_det && m_cnt == QUAL)) begin
            m_st = M_CONV; m_start = 1'b1; m_cnt = 0;
          end else if (!carrier_det) m_cnt = 0;
          else if (m_cnt < QUAL) m_cnt++;
        end
        M_CONV: if (adc_done) begin
          m_status = {2'b00, 1'b1, adc_code}; m_st = M_HALT;
        end
        default: ;
      endcase
    end
  endtask

  task automatic cycle();
    adc_done = 1'b0;
    if (conv_wait > 0) begin
      conv_wait--;
      if (conv_wait == 0) begin
        adc_done = 1'b1; adc_code = CODE_W'($urandom); conv_wait = -1;
      end
    end else if (spurious && m_st != M_CONV && $urandom_range(0, 3) == 0) begin
      adc_done = 1'b1; adc_code = CODE_W'($urandom);
    end
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check((tag != "") ? tag : state_tag(m_st), rssi_status, m_status);
    check("R5", {7'b0, adc_start}, {7'b0, m_start});
    check("R9", {6'b0, rssi_status[7:6]}, 8'h00);
    if (adc_start) conv_wait = $urandom_range(1, 6);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    repeat (3) cycle();
    rst_n = 1'b1;
    cycle();
    check("R1", rssi_status, 8'h00);

    // R2: exact qualification boundary
    tag = "R2";
    rx_en = 1'b1; cycle();
    carrier_det = 1'b1;
    repeat (QUAL) cycle();
    check("R2", {7'b0, adc_start}, 8'h00);
    cycle();
    check("R2", {7'b0, adc_start}, 8'h01);
    carrier_det = 1'b0;
    tag = "R6";
    repeat (8) cycle();
    check("R6", {7'b0, rssi_status[5]}, 8'h01);

    // R7: halted session ignores everything
    tag = "R7";
    carrier_det = 1'b1; force_cd = 1'b1; spurious = 1;
    repeat (20) cycle();
    force_cd = 1'b0; spurious = 0; carrier_det = 1'b0;

    // R8: receive off clears, then re-arm
    tag = "R8";
    rx_en = 1'b0; cycle();
    check("R8", rssi_status, 8'h00);
    rx_en = 1'b1; cycle();

    // R3: carrier gap one sample short of qualification
    tag = "R3";
    carrier_det = 1'b1; repeat (QUAL) cycle();
    carrier_det = 1'b0; cycle();
    carrier_det = 1'b1; repeat (QUAL) cycle();
    check("R3", {7'b0, adc_start}, 8'h00);
    cycle();
    check("R3", {7'b0, adc_start}, 8'h01);
    carrier_det = 1'b0;
    repeat (8) cycle();

    // R10 then R4: stray done while armed, then force on a silent channel
    rx_en = 1'b0; cycle();
    rx_en = 1'b1; cycle();
    tag = "R10"; spurious = 1;
    repeat (20) cycle();
    check("R10", rssi_status, 8'h00);
    spurious = 0;
    tag = "R4"; force_cd = 1'b1; cycle(); force_cd = 1'b0;
    check("R4", {7'b0, adc_start}, 8'h01);
    repeat (8) cycle();
    check("R4", {7'b0, rssi_status[5]}, 8'h01);

    // Constrained random sessions
    tag = ""; spurious = 1;
    repeat (4000) begin
      if ($urandom_range(0, 99) < 3) rx_en = ~rx_en;
      if ($urandom_range(0, 99) < 10) carrier_det = ~carrier_det;
      force_cd = ($urandom_range(0, 99) < 2);
      cycle();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule